// File: doc/BRIEF.md
# Bus-Master Disk DMA Channel Register Block

This block is the software-facing register window of one bus-master DMA channel for a disk controller. Software programs it through an eight-byte window. It writes the physical address of a descriptor table, picks a transfer direction and sets a start bit. The block then tells a separate data-movement engine to run. The engine reports back through done, error and busy inputs. The block turns those reports into status flags that software polls and clears.

The run control is a three-state machine. The states are `ST_IDLE`, `ST_ACTIVE` and `ST_HALTED`.
- `ST_IDLE` moves to `ST_ACTIVE` when a command write sets the start bit.
- `ST_ACTIVE` moves to `ST_IDLE` when a command write clears the start bit.
- `ST_ACTIVE` moves to `ST_HALTED` when the engine reports done or error.
- `ST_HALTED` moves to `ST_IDLE` when a command write clears the start bit.
- Every other combination holds the current state.

While the machine is in `ST_HALTED`, the start bit still reads 1. A fresh start therefore needs a write of 0 first, and a later write of 1.

One status byte mixes four kinds of bit:
- a live active flag;
- error and interrupt flags that are cleared by writing 1 to them;
- a busy indication from the engine;
- two per-drive DMA-capable flags that software reads and writes plainly.

A completion is good when the low three status bits read 100b.

Top module: `bmdma_regif`

## Requirements
- R1: After reset, every register reads 0x00 and `eng_run`, `eng_start` and `eng_dir_to_mem` are 0.
- R2: Offsets 1 and 3 are plain read/write bytes. Offsets 4 to 7 hold the table pointer, with offset 4 as the least significant byte. `eng_table_base` presents the whole pointer.
- R3: Bits 1:0 of the table pointer always read 0, whatever value was written.
- R4: Writing command offset 0 with bit 0 = 1 while in `ST_IDLE` enters `ST_ACTIVE`. `eng_start` pulses high for exactly the one cycle after the write, and `eng_run` stays high while the state is `ST_ACTIVE`. Status bit 0 reads 1 in `ST_ACTIVE`.
- R5: Command bit 3 is stored and reads back. It drives `eng_dir_to_mem`, where 1 means device to memory.
- R6: While in `ST_ACTIVE`, writes to command bit 3 and to the pointer bytes are ignored.
- R7: Engine done in `ST_ACTIVE` ends the run and sets status bit 2. Engine error in `ST_ACTIVE` ends the run and sets status bit 1. Both inputs are ignored outside `ST_ACTIVE`. After a clean done, the status low bits read 100b.
- R8: Writing 1 to status bit 1 or bit 2 clears that bit, and writing 0 leaves it unchanged. When a set event and a clear write meet in the same cycle, the set wins.
- R9: Status bits 5 and 6 are plain read/write flags, one per drive.
- R10: Status bits 3 and 4 both read 1 when the state is `ST_ACTIVE` and `eng_busy` is high, and read 0 otherwise.
- R11: Writing command bit 0 = 0 in `ST_ACTIVE` stops the run without setting the interrupt. In `ST_HALTED`, command bit 0 reads 1, and writing 1 again does not restart the engine.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | 3 | Byte offset in the register window |
| reg_wdata | input | 8 | Write data |
| reg_wr | input | 1 | Write strobe, one byte per cycle |
| reg_rdata | output | 8 | Read data for `reg_addr`, combinational |
| eng_done | input | 1 | Engine finished the table |
| eng_error | input | 1 | Engine hit a bus or table fault |
| eng_busy | input | 1 | Engine still moving data |
| eng_start | output | 1 | One-cycle pulse at run start |
| eng_run | output | 1 | Engine may run |
| eng_dir_to_mem | output | 1 | 1: device to memory |
| eng_table_base | output | 32 | Descriptor table address |

## Verification
The bench builds the block with its default parameters. These are a 32-bit pointer over byte lanes, two alignment bits and two drive flags. With them, the bench can check the lane order of all four pointer bytes and the masking of the alignment bits. The same default build lets it exercise both drive flags alongside the clear-on-one bits in a single byte. The sequence walks every state transition. It also forces the corner cases: a clear write in the same cycle as a done, done and error together, and a restart attempt from `ST_HALTED`.

// File: rtl/bmdma_regs_pkg.sv
package bmdma_regs_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_ACTIVE = 2'd1,
        ST_HALTED = 2'd2
    } run_state_e;

    // window offsets
    localparam logic [2:0] OFS_CMD  = 3'd0;
    localparam logic [2:0] OFS_VND0 = 3'd1;
    localparam logic [2:0] OFS_STAT = 3'd2;
    localparam logic [2:0] OFS_VND1 = 3'd3;
    localparam logic [2:0] OFS_PTR  = 3'd4;

    // command bits
    localparam int CMD_RUN_BIT = 0;
    localparam int CMD_DIR_BIT = 3;

    // status bits
    localparam int ST_ACT_BIT   = 0;
    localparam int ST_ERR_BIT   = 1;
    localparam int ST_IRQ_BIT   = 2;
    localparam int ST_BUSY_LO   = 3;
    localparam int ST_BUSY_HI   = 4;
    localparam int ST_DRV_BASE  = 5;

endpackage

// File: rtl/bmdma_run_fsm.sv
module bmdma_run_fsm
    import bmdma_regs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cmd_wr,
    input  logic cmd_run_bit,
    input  logic cmd_dir_bit,
    input  logic done_i,
    input  logic err_i,
    output logic active_o,
    output logic run_rd_o,
    output logic start_pulse_o,
    output logic dir_o
);

    run_state_e state_q, state_d;
    logic       start_q;
    logic       dir_q;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (cmd_wr && cmd_run_bit) state_d = ST_ACTIVE;
            ST_ACTIVE: begin
                if (cmd_wr && !cmd_run_bit)  state_d = ST_IDLE;
                else if (done_i || err_i)    state_d = ST_HALTED;
            end
            ST_HALTED: if (cmd_wr && !cmd_run_bit) state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            start_q <= 1'b0;
            dir_q   <= 1'b0;
        end else begin
            start_q <= (state_d == ST_ACTIVE) && (state_q != ST_ACTIVE);
            if (cmd_wr && state_q != ST_ACTIVE) dir_q <= cmd_dir_bit;
        end
    end

    always_comb begin
        active_o      = (state_q == ST_ACTIVE);
        run_rd_o      = (state_q != ST_IDLE);
        start_pulse_o = start_q;
        dir_o         = dir_q;
    end

    assert_start_single_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |=> !start_pulse_o);
    assert_start_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
        start_pulse_o |-> active_o);
    assert_end_on_event_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_o && (done_i || err_i)) |=> !active_o);
    assert_dir_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        active_o |=> $stable(dir_o));

endmodule

// File: rtl/bmdma_status_regs.sv
module bmdma_status_regs
    import bmdma_regs_pkg::*;
#(
    parameter int DATA_W     = 8,
    parameter int NUM_DRIVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              stat_wr,
    input  logic [DATA_W-1:0] wdata,
    input  logic              active_i,
    input  logic              busy_i,
    input  logic              done_i,
    input  logic              err_i,
    output logic [DATA_W-1:0] status_o
);

    logic                  irq_q, err_q;
    logic [NUM_DRIVES-1:0] drv_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq_q <= 1'b0;
            err_q <= 1'b0;
        end else begin
            irq_q <= (active_i && done_i) || (irq_q && !(stat_wr && wdata[ST_IRQ_BIT]));
            err_q <= (active_i && err_i)  || (err_q && !(stat_wr && wdata[ST_ERR_BIT]));
        end
    end

    for (genvar g = 0; g < NUM_DRIVES; g++) begin : g_drv
        always_ff @(posedge clk) begin
            if (!rst_n)       drv_q[g] <= 1'b0;
            else if (stat_wr) drv_q[g] <= wdata[ST_DRV_BASE + g];
        end
    end

    always_comb begin
        status_o = '0;
        status_o[ST_ACT_BIT] = active_i;
        status_o[ST_ERR_BIT] = err_q;
        status_o[ST_IRQ_BIT] = irq_q;
        status_o[ST_BUSY_LO] = active_i && busy_i;
        status_o[ST_BUSY_HI] = active_i && busy_i;
        status_o[ST_DRV_BASE +: NUM_DRIVES] = drv_q;
    end

    assert_irq_on_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (active_i && done_i) |=> status_o[ST_IRQ_BIT]);
    assert_w1c_irq_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_wr && wdata[ST_IRQ_BIT] && !(active_i && done_i)) |=> !status_o[ST_IRQ_BIT]);
    assert_err_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (status_o[ST_ERR_BIT] && !(stat_wr && wdata[ST_ERR_BIT])) |=> status_o[ST_ERR_BIT]);

endmodule

// File: rtl/bmdma_table_ptr.sv
module bmdma_table_ptr #(
    parameter int PTR_W      = 32,
    parameter int DATA_W     = 8,
    parameter int ALIGN_BITS = 2,
    localparam int LANES     = PTR_W / DATA_W,
    localparam int LANE_W    = (LANES > 1) ? $clog2(LANES) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr,
    input  logic [LANE_W-1:0] lane,
    input  logic [DATA_W-1:0] wdata,
    input  logic              frozen,
    output logic [PTR_W-1:0]  ptr_o,
    output logic [DATA_W-1:0] rd_o
);

    localparam logic [DATA_W-1:0] KEEP_MASK = ~DATA_W'((1 << ALIGN_BITS) - 1);

    logic [PTR_W-1:0] ptr_q;

    for (genvar g = 0; g < LANES; g++) begin : g_lane
        localparam logic [DATA_W-1:0] LANE_MASK = (g == 0) ? KEEP_MASK : '1;
        always_ff @(posedge clk) begin
            if (!rst_n)
                ptr_q[g*DATA_W +: DATA_W] <= '0;
            else if (wr && !frozen && lane == LANE_W'(g))
                ptr_q[g*DATA_W +: DATA_W] <= wdata & LANE_MASK;
        end
    end

    always_comb begin
        ptr_o = ptr_q;
        rd_o  = ptr_q[lane*DATA_W +: DATA_W];
    end

    assert_ptr_frozen_R6: assert property (@(posedge clk) disable iff (!rst_n)
        frozen |=> $stable(ptr_o));
    assert_ptr_aligned_R3: assert property (@(posedge clk) disable iff (!rst_n)
        ptr_o[ALIGN_BITS-1:0] == '0);

endmodule

// File: rtl/bmdma_regif.sv
module bmdma_regif
    import bmdma_regs_pkg::*;
#(
    parameter int ADDR_W     = 3,
    parameter int DATA_W     = 8,
    parameter int PTR_W      = 32,
    parameter int ALIGN_BITS = 2,
    parameter int NUM_DRIVES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    input  logic              reg_wr,
    output logic [DATA_W-1:0] reg_rdata,
    input  logic              eng_done,
    input  logic              eng_error,
    input  logic              eng_busy,
    output logic              eng_start,
    output logic              eng_run,
    output logic              eng_dir_to_mem,
    output logic [PTR_W-1:0]  eng_table_base
);

    localparam int LANES  = PTR_W / DATA_W;
    localparam int LANE_W = (LANES > 1) ? $clog2(LANES) : 1;

    logic cmd_hit, stat_hit, ptr_hit, vnd0_hit, vnd1_hit;
    logic active, run_rd, dir;
    logic [DATA_W-1:0] status, ptr_rd, vnd0_q, vnd1_q;

    always_comb begin
        cmd_hit  = reg_wr && (reg_addr == ADDR_W'(OFS_CMD));
        stat_hit = reg_wr && (reg_addr == ADDR_W'(OFS_STAT));
        vnd0_hit = reg_wr && (reg_addr == ADDR_W'(OFS_VND0));
        vnd1_hit = reg_wr && (reg_addr == ADDR_W'(OFS_VND1));
        ptr_hit  = reg_wr && (reg_addr >= ADDR_W'(OFS_PTR));
    end

    bmdma_run_fsm u_fsm (
        .clk           (clk),
        .rst_n         (rst_n),
        .cmd_wr        (cmd_hit),
        .cmd_run_bit   (reg_wdata[CMD_RUN_BIT]),
        .cmd_dir_bit   (reg_wdata[CMD_DIR_BIT]),
        .done_i        (eng_done),
        .err_i         (eng_error),
        .active_o      (active),
        .run_rd_o      (run_rd),
        .start_pulse_o (eng_start),
        .dir_o         (dir)
    );

    bmdma_status_regs #(.DATA_W(DATA_W), .NUM_DRIVES(NUM_DRIVES)) u_stat (
        .clk      (clk),
        .rst_n    (rst_n),
        .stat_wr  (stat_hit),
        .wdata    (reg_wdata),
        .active_i (active),
        .busy_i   (eng_busy),
        .done_i   (eng_done),
        .err_i    (eng_error),
        .status_o (status)
    );

    bmdma_table_ptr #(.PTR_W(PTR_W), .DATA_W(DATA_W), .ALIGN_BITS(ALIGN_BITS)) u_ptr (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr     (ptr_hit),
        .lane   (reg_addr[LANE_W-1:0]),
        .wdata  (reg_wdata),
        .frozen (active),
        .ptr_o  (eng_table_base),
        .rd_o   (ptr_rd)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vnd0_q <= '0;
            vnd1_q <= '0;
        end else begin
            if (vnd0_hit) vnd0_q <= reg_wdata;
            if (vnd1_hit) vnd1_q <= reg_wdata;
        end
    end

    always_comb begin
        eng_run        = active;
        eng_dir_to_mem = dir;
        reg_rdata      = '0;
        if (reg_addr >= ADDR_W'(OFS_PTR)) reg_rdata = ptr_rd;
        else if (reg_addr == ADDR_W'(OFS_CMD)) begin
            reg_rdata[CMD_RUN_BIT] = run_rd;
            reg_rdata[CMD_DIR_BIT] = dir;
        end
        else if (reg_addr == ADDR_W'(OFS_VND0)) reg_rdata = vnd0_q;
        else if (reg_addr == ADDR_W'(OFS_STAT)) reg_rdata = status;
        else if (reg_addr == ADDR_W'(OFS_VND1)) reg_rdata = vnd1_q;
    end

    assert_run_tracks_status_R4: assert property (@(posedge clk) disable iff (!rst_n)
        eng_run == status[ST_ACT_BIT]);

endmodule

// File: tb/test_bmdma_regif.sv
module test_bmdma_regif;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  reg_addr = '0;
    logic [7:0]  reg_wdata = '0;
    logic        reg_wr = 1'b0;
    logic [7:0]  reg_rdata;
    logic        eng_done = 1'b0, eng_error = 1'b0, eng_busy = 1'b0;
    logic        eng_start, eng_run, eng_dir_to_mem;
    logic [31:0] eng_table_base;

    always #10 clk = ~clk;

    bmdma_regif i_bmdma_regif (
        .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wdata(reg_wdata),
        .reg_wr(reg_wr), .reg_rdata(reg_rdata), .eng_done(eng_done),
        .eng_error(eng_error), .eng_busy(eng_busy), .eng_start(eng_start),
        .eng_run(eng_run), .eng_dir_to_mem(eng_dir_to_mem),
        .eng_table_base(eng_table_base)
    );

    // scoreboard: kind 0 = read data at mon_addr, 1 = {start,run,dir}, 2 = table base
    int          kind_q[$];
    logic [31:0] exp_q[$];
    string       tag_q[$];
    logic        mon_req = 1'b0;
    int          n_cmp = 0, n_bad = 0;
    logic        bench_done = 1'b0;

    always @(negedge clk) begin
        if (mon_req && kind_q.size() > 0) begin
            int k;
            logic [31:0] e, o;
            string t;
            k = kind_q.pop_front();
            e = exp_q.pop_front();
            t = tag_q.pop_front();
            if (k == 0)      o = {24'h0, reg_rdata};
            else if (k == 1) o = {29'h0, eng_start, eng_run, eng_dir_to_mem};
            else             o = eng_table_base;
            n_cmp++;
            if (o !== e) begin
                n_bad++;
                $display("FAIL %s: got 0x%0h expected 0x%0h", t, o, e);
            end
        end
    end

    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
        @(posedge clk); #2;
        reg_wr = 1'b0;
    endtask

    task automatic expect_val(input int k, input logic [2:0] a, input logic [31:0] e, input string t);
        reg_addr = a;
        kind_q.push_back(k); exp_q.push_back(e); tag_q.push_back(t);
        mon_req = 1'b1;
        @(posedge clk); #2;
        mon_req = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, input logic [7:0] e, input string t);
        expect_val(0, a, {24'h0, e}, t);
    endtask

    task automatic eng(input logic [2:0] e, input string t);
        expect_val(1, reg_addr, {29'h0, e}, t);
    endtask

    task automatic pulse_done();
        eng_done = 1'b1; @(posedge clk); #2; eng_done = 1'b0;
    endtask

    task automatic pulse_err();
        eng_error = 1'b1; @(posedge clk); #2; eng_error = 1'b0;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!bench_done) begin
            n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(posedge clk); #2;

        rd(3'd2, 8'h00, "R1 status after reset");
        rd(3'd0, 8'h00, "R1 command after reset");
        rd(3'd4, 8'h00, "R1 pointer after reset");
        eng(3'b000, "R1 engine outputs after reset");

        wr(3'd4, 8'h77); wr(3'd5, 8'h56); wr(3'd6, 8'h34); wr(3'd7, 8'h12);
        rd(3'd4, 8'h74, "R3 pointer low bits masked");
        rd(3'd6, 8'h34, "R2 pointer byte 2");
        expect_val(2, 3'd0, 32'h1234_5674, "R2 table base lane order");
        wr(3'd1, 8'hA5); wr(3'd3, 8'h3C);
        rd(3'd1, 8'hA5, "R2 vendor byte 1");
        rd(3'd3, 8'h3C, "R2 vendor byte 3");

        wr(3'd0, 8'h08);
        rd(3'd0, 8'h08, "R5 direction readback");
        eng(3'b001, "R5 direction to engine");

        wr(3'd0, 8'h09);
        eng(3'b111, "R4 start pulse with run");
        eng(3'b011, "R4 start pulse one cycle only");
        rd(3'd2, 8'h01, "R4 status active");

        wr(3'd0, 8'h01);
        rd(3'd0, 8'h09, "R6 direction frozen while active");
        wr(3'd4, 8'h00);
        rd(3'd4, 8'h74, "R6 pointer frozen while active");

        eng_busy = 1'b1;
        rd(3'd2, 8'h19, "R10 busy pair while active");
        eng_busy = 1'b0;

        pulse_done();
        rd(3'd2, 8'h04, "R7 good completion 100b");
        eng(3'b001, "R7 run cleared by done");
        rd(3'd0, 8'h09, "R11 start bit reads 1 when halted");
        eng_busy = 1'b1;
        rd(3'd2, 8'h04, "R10 busy pair hidden when not active");
        eng_busy = 1'b0;
        wr(3'd0, 8'h09);
        eng(3'b001, "R11 no restart from halted");

        wr(3'd2, 8'h04);
        rd(3'd2, 8'h00, "R8 interrupt cleared by one");
        wr(3'd2, 8'h60);
        rd(3'd2, 8'h60, "R9 drive flags set");
        wr(3'd2, 8'h66);
        rd(3'd2, 8'h60, "R9 drive flags kept by read-or-6 idiom");

        wr(3'd0, 8'h00);
        rd(3'd0, 8'h00, "R11 halted back to idle");
        wr(3'd0, 8'h01);
        eng(3'b110, "R4 restart after stop, dir now 0");
        pulse_err();
        rd(3'd2, 8'h62, "R7 error sets bit 1 and ends run");
        eng(3'b000, "R7 run cleared by error");

        wr(3'd0, 8'h00);
        wr(3'd2, 8'h66);
        rd(3'd2, 8'h60, "R8 error cleared by one");
        wr(3'd0, 8'h01);
        fork
            wr(3'd2, 8'h64);
            pulse_done();
        join
        rd(3'd2, 8'h64, "R8 set wins over same-cycle clear");

        wr(3'd0, 8'h00);
        wr(3'd2, 8'h66);
        wr(3'd0, 8'h01);
        wr(3'd0, 8'h00);
        rd(3'd2, 8'h60, "R11 stop without interrupt");
        eng(3'b000, "R11 run cleared by stop");

        pulse_done();
        pulse_err();
        rd(3'd2, 8'h60, "R7 engine reports ignored while idle");

        wr(3'd0, 8'h01);
        fork
            pulse_done();
            pulse_err();
        join
        rd(3'd2, 8'h66, "R7 done and error together");

        bench_done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule